// File: doc/BRIEF.md
# Programmable-Priority Interrupt Resolver

This block picks, at each moment, the most urgent interrupt that is live in each of the two interrupt classes: the fast class (FIQ) and the normal class (IRQ). Urgency does not follow the source numbers. It comes from a table that software fills: each of the 40 priority slots names one source. Slot 0 outranks slot 1, slot 1 outranks slot 2, and so on. A source is live when it is pending and its enable bit is set. Its class comes from a per-source select bit.

The resolver is purely combinational. The table registers, the pending, enable and select vectors, and the bus decode all sit outside it. Its single output is the word returned when software reads the controller's highest-priority register. That word holds two independent results: the FIQ winner and the IRQ winner. Each result has a valid flag and a 6-bit source ID.

Each table slot enters as a 7-bit field: bit 6 is the valid flag and bits 5:0 are the source ID. Slot n occupies bits n*7+6 down to n*7 of `slot_tbl`. Source k (0..63) uses bit k of the 64-bit vector formed as {hi, lo}. The `lo` vector holds sources 0..31 and the `hi` vector holds sources 32..63.

Top module: `prio_resolver`

## Requirements
- R1: A slot whose valid flag (bit 6 of its field) is 0 takes no part in resolution, whatever its ID.
- R2: A slot whose ID is 40 or more takes no part in resolution, even when its valid flag is 1.
- R3: A slot is a candidate only when its source is both pending and enabled. A source that is pending but masked, or enabled but not pending, never wins.
- R4: A candidate competes in the FIQ class when its source's select bit is 1, and in the IRQ class when that bit is 0. The two classes are resolved independently.
- R5: Within each class, the candidate in the lowest-numbered slot wins.
- R6: A FIQ winner is reported by setting bit 15 of `winner_word` and placing its ID in bits 5:0.
- R7: An IRQ winner is reported by setting bit 31 of `winner_word` and placing its ID in bits 21:16.
- R8: A class with no winner shows 0 in its flag bit and 0x3F in its ID field. With no winner in either class, the word is 0x003F003F.
- R9: When one source ID appears in several slots, the lowest such slot gives it its rank.
- R10: Bits 30:22 and 14:6 of `winner_word` are always 0.
- R11: The output has no register. It reflects the current inputs within the same clock cycle that they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_tbl | input | NSRC*7 (280) | Priority table. Slot n is {valid, id[5:0]} at bits n*7 +: 7. |
| pend_lo | input | 32 | Pending flags for sources 0..31 |
| pend_hi | input | 32 | Pending flags for sources 32..63 |
| mask_lo | input | 32 | Enable flags for sources 0..31 |
| mask_hi | input | 32 | Enable flags for sources 32..63 |
| fsel_lo | input | 32 | FIQ-class select for sources 0..31 (1 = FIQ) |
| fsel_hi | input | 32 | FIQ-class select for sources 32..63 (1 = FIQ) |
| winner_word | output | 32 | Packed result: {irq_valid, 9'b0, irq_id, fiq_valid, 9'b0, fiq_id} |

## Verification
No register lies between any input and `winner_word`, so every result is due in the same cycle as its stimulus. The bench applies each new input set just after a rising edge. It reads the word at the following falling edge, half a period later, once the combinational logic has settled. The expected word comes from a model in the bench. That model scans the slots upward and stops at the first winner in each class, which is a different structure from the downward overwrite loop in the RTL. The model is applied to directed cases, to a sweep of a single slot over every 6-bit ID in both classes, and to randomized tables that include invalid and out-of-range entries.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NSRC = 40
) (
  input  logic [NSRC*7-1:0] slot_tbl,
  input  logic [31:0]       pend_lo,
  input  logic [31:0]       pend_hi,
  input  logic [31:0]       mask_lo,
  input  logic [31:0]       mask_hi,
  input  logic [31:0]       fsel_lo,
  input  logic [31:0]       fsel_hi,
  output logic [31:0]       winner_word
);
  localparam int IDW = 6;
  localparam int SLW = IDW + 1;
  localparam logic [IDW-1:0] NONE = '1;

  logic [63:0] live;
  logic [63:0] fsel;
  logic           f_hit, i_hit;
  logic [IDW-1:0] f_id, i_id;

  assign live = {pend_hi, pend_lo} & {mask_hi, mask_lo};
  assign fsel = {fsel_hi, fsel_lo};

  always_comb begin
    f_hit = 1'b0;
    f_id  = NONE;
    i_hit = 1'b0;
    i_id  = NONE;
    for (int s = NSRC - 1; s >= 0; s--) begin
      logic [IDW-1:0] sid;
      logic           ok;
      sid = slot_tbl[s*SLW +: IDW];
      ok  = slot_tbl[s*SLW + IDW] && (int'(sid) < NSRC);
      if (ok && live[sid]) begin
        if (fsel[sid]) begin
          f_hit = 1'b1;
          f_id  = sid;
        end else begin
          i_hit = 1'b1;
          i_id  = sid;
        end
      end
    end
  end

  assign winner_word = {i_hit, 9'd0, i_id, f_hit, 9'd0, f_id};
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NSRC = 40
) (
  input logic [NSRC*7-1:0] slot_tbl,
  input logic [31:0]       pend_lo,
  input logic [31:0]       pend_hi,
  input logic [31:0]       mask_lo,
  input logic [31:0]       mask_hi,
  input logic [31:0]       fsel_lo,
  input logic [31:0]       fsel_hi,
  input logic [31:0]       winner_word
);
  logic [63:0] act;
  logic [63:0] sel;
  logic [5:0]  fid, iid;
  logic        f_listed, i_listed;

  assign act = {pend_hi, pend_lo} & {mask_hi, mask_lo};
  assign sel = {fsel_hi, fsel_lo};
  assign fid = winner_word[5:0];
  assign iid = winner_word[21:16];

  always_comb begin
    f_listed = 1'b0;
    i_listed = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (slot_tbl[s*7+6] && slot_tbl[s*7 +: 6] == fid) f_listed = 1'b1;
      if (slot_tbl[s*7+6] && slot_tbl[s*7 +: 6] == iid) i_listed = 1'b1;
    end
  end

  always_comb begin
    AST_SPARE_ZERO: assert ((winner_word & 32'h7FC0_7FC0) == 32'd0); // R10
    AST_FIQ_IDLE: assert (winner_word[15] || fid == 6'h3F); // R8
    AST_IRQ_IDLE: assert (winner_word[31] || iid == 6'h3F); // R8
    AST_FIQ_LIVE: assert (!winner_word[15] || (int'(fid) < NSRC && act[fid] && sel[fid])); // R4
    AST_IRQ_LIVE: assert (!winner_word[31] || (int'(iid) < NSRC && act[iid] && !sel[iid])); // R4
    AST_FIQ_LISTED: assert (!winner_word[15] || f_listed); // R1
    AST_IRQ_LISTED: assert (!winner_word[31] || i_listed); // R1
  end
endmodule

bind prio_resolver prio_resolver_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/sim_prio_resolver.sv
module sim_prio_resolver;
  localparam int NSRC = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              tb_v  [NSRC];
  logic [5:0]        tb_id [NSRC];
  logic [NSRC*7-1:0] slot_flat;
  logic [31:0] pend_lo, pend_hi, mask_lo, mask_hi, fsel_lo, fsel_hi;
  logic [31:0] winner_word;
  int n_cmp = 0;
  int n_bad = 0;

  always_comb
    for (int s = 0; s < NSRC; s++) slot_flat[s*7 +: 7] = {tb_v[s], tb_id[s]};

  prio_resolver u0 (
    .slot_tbl(slot_flat), .pend_lo(pend_lo), .pend_hi(pend_hi),
    .mask_lo(mask_lo), .mask_hi(mask_hi), .fsel_lo(fsel_lo), .fsel_hi(fsel_hi),
    .winner_word(winner_word)
  );

  function automatic logic [31:0] model();
    logic fv = 1'b0, iv = 1'b0;
    logic [5:0] fi = 6'h3F, ii = 6'h3F;
    logic [31:0] w;
    for (int s = 0; s < NSRC; s++) begin
      int id = int'(tb_id[s]);
      logic p, m, f;
      if (!tb_v[s] || id >= NSRC) continue;
      p = (id < 32) ? pend_lo[id] : pend_hi[id-32];
      m = (id < 32) ? mask_lo[id] : mask_hi[id-32];
      f = (id < 32) ? fsel_lo[id] : fsel_hi[id-32];
      if (!(p && m)) continue;
      if (f && !fv) begin fv = 1'b1; fi = tb_id[s]; end
      if (!f && !iv) begin iv = 1'b1; ii = tb_id[s]; end
    end
    w = 32'd0;
    w[31] = iv; w[21:16] = ii; w[15] = fv; w[5:0] = fi;
    return w;
  endfunction

  task automatic clear_all();
    for (int s = 0; s < NSRC; s++) begin tb_v[s] = 1'b0; tb_id[s] = 6'd0; end
    pend_lo = 0; pend_hi = 0; mask_lo = 0; mask_hi = 0; fsel_lo = 0; fsel_hi = 0;
  endtask

  task automatic set_src(input int id, input logic p, input logic m, input logic f);
    if (id < 32) begin pend_lo[id] = p; mask_lo[id] = m; fsel_lo[id] = f; end
    else begin pend_hi[id-32] = p; mask_hi[id-32] = m; fsel_hi[id-32] = f; end
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    @(negedge clk);
    n_cmp++;
    if (winner_word !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, winner_word, exp);
    end
    @(posedge clk);
    #0.5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    #0.5;
    check("R8 idle", 32'h003F003F);

    tb_v[0] = 1'b0; tb_id[0] = 6'd3; set_src(3, 1, 1, 1);
    check("R1 invalid slot", 32'h003F003F);

    clear_all(); tb_v[0] = 1'b1; tb_id[0] = 6'd40; tb_v[1] = 1'b1; tb_id[1] = 6'd63;
    pend_hi = '1; mask_hi = '1;
    check("R2 id out of range", 32'h003F003F);

    clear_all(); tb_v[0] = 1'b1; tb_id[0] = 6'd5; set_src(5, 1, 0, 0);
    check("R3 masked", 32'h003F003F);
    set_src(5, 0, 1, 0);
    check("R3 not pending", 32'h003F003F);
    set_src(5, 1, 1, 0);
    check("R7 irq winner", 32'h8005003F);
    set_src(5, 1, 1, 1);
    check("R6 fiq winner", 32'h003F8005);

    clear_all();
    tb_v[2] = 1'b1; tb_id[2] = 6'd39; set_src(39, 1, 1, 1);
    tb_v[7] = 1'b1; tb_id[7] = 6'd1;  set_src(1, 1, 1, 1);
    tb_v[3] = 1'b1; tb_id[3] = 6'd20; set_src(20, 1, 1, 0);
    tb_v[9] = 1'b1; tb_id[9] = 6'd33; set_src(33, 1, 1, 0);
    check("R4 R5 both classes", 32'h80148027);
    tb_v[2] = 1'b0;
    check("R5 next fiq slot", 32'h80148001);

    clear_all();
    tb_v[4] = 1'b1; tb_id[4] = 6'd30; tb_v[6] = 1'b1; tb_id[6] = 6'd12;
    tb_v[8] = 1'b1; tb_id[8] = 6'd30;
    set_src(30, 1, 1, 0); set_src(12, 1, 1, 0);
    check("R9 duplicate id", 32'h801E003F);
    tb_v[4] = 1'b0;
    check("R9 duplicate lower gone", 32'h800C003F);

    for (int id = 0; id < 64; id++)
      for (int f = 0; f < 2; f++) begin
        clear_all(); pend_lo = '1; pend_hi = '1; mask_lo = '1; mask_hi = '1;
        fsel_lo = {32{f[0]}}; fsel_hi = {32{f[0]}};
        tb_v[NSRC-1] = 1'b1; tb_id[NSRC-1] = 6'(id);
        check("R2 R6 R7 slot sweep", model());
      end

    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < NSRC; s++) begin
        tb_v[s]  = ($urandom % 4) != 0;
        tb_id[s] = 6'($urandom % 48);
      end
      pend_lo = $urandom; pend_hi = $urandom; fsel_lo = $urandom; fsel_hi = $urandom;
      mask_lo = $urandom; mask_hi = $urandom;
      for (int k = 0; k < n % 4; k++) begin
        mask_lo &= $urandom; mask_hi &= $urandom; pend_lo &= $urandom;
      end
      check("R5 R10 R11 random", model());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule